// File: doc/BRIEF.md
# Multi-Rate Switching Clock Generator

This block produces every switching phase needed by a chopper-stabilised, auto-zeroed sensor amplifier from one master clock of nominally 200 kHz. A phase engine steps six modulo counters together off the master edge, all cleared by one synchronous reset. A waveform stage turns the counter states into 25 registered phase signals. These signals drive the switches of the main-path chopper, two ping-pong auto-zero amplifiers, a slower chopper in the compensation path, the gain controller, and the switched-capacitor filters.

The divide ratios from the master clock are 2, 16, 80, 200, 8 and 256. The auto-zero and compensation-chopper phases are non-overlapping, with a one-master-cycle low gap around every phase change. Each of those phases also has an inverted copy. Every output is aligned to master-clock edges. After reset, every output starts from phase zero of its divider.

Top module: `clkgen_multirate`

## Requirements
- R1: While `syncRst` is high at a master edge, the bus takes the phase-zero word 25'h1D73C15 on that edge and holds it for as long as reset stays high (bit 21 excluded, see R8).
- R2: Bits 0, 2 and 4 are high in even master phases and low in odd ones, and bits 1, 3 and 5 are their inverse, so each toggles every master cycle (divide by 2).
- R3: Auto-zero timing uses a 16-cycle period with phase p = count mod 16. Bit 6 (amplifier 0 zeroing) is high for p in 1..7, and bit 8 (amplifier 0 amplifying) is high for p in 9..15.
- R4: Ping-pong: bit 7 (amplifier 1 zeroing) equals bit 8, and bit 9 (amplifier 1 amplifying) equals bit 6. The two zeroing phases are never high together, and neither are the two amplifying phases.
- R5: Bits 10, 11, 12 and 13 are the inverses of bits 6, 7, 8 and 9 respectively.
- R6: Compensation chopper timing uses an 80-cycle period with phase q. Bit 14 is high for q in 1..39 and bit 15 for q in 41..79. Bit 16 is high for q below 40. Bits 17, 18 and 19 are the inverses of bits 14, 15 and 16.
- R7: Bit 20 (gain controller) has a 200-cycle period and is high for the first 100 cycles.
- R8: Bit 21 follows the master clock level. Bit 22 has period 8 and is high for the first 4 cycles. Bit 23 has period 16 and is high for the first 8. Bit 24 has period 256 and is high for the first 128.
- R9: Each non-overlapping pair (bits 6/8 and bits 14/15) is low together for exactly one master cycle at each hand-over: p = 0 and 8, and q = 0 and 40.
- R10: A reset applied mid-run restarts all dividers, so the n-th edge after release shows phase n of every divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| masterClk | input | 1 | Master clock, all derived edges follow its rising edge |
| syncRst | input | 1 | Synchronous active-high reset to phase zero |
| phaseBus | output | 25 | Flat bus of derived switching phases, layout per requirements |

## Verification
Every derived bit is a register loaded from the next divider phase. The value visible after the n-th rising edge following reset release is therefore the phase-n pattern, with no extra latency. The bench samples registered bits at the falling edge between rising edges and compares them against an independently computed phase-n word. It samples bit 21, which is the master clock itself, one nanosecond after each edge. The directed cases count edges from a fresh reset to reach each hand-over point before sampling.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NUM_DIV   = 6;
  localparam int PH_W      = 16;
  localparam int NUM_OUT   = 25;
  localparam int CHOP_PAIRS = 3;

  // divider slots
  localparam int IDX_CHOP = 0;
  localparam int IDX_AZ   = 1;
  localparam int IDX_CMP  = 2;
  localparam int IDX_GAIN = 3;
  localparam int IDX_FMID = 4;
  localparam int IDX_FSLO = 5;

  typedef struct packed {
    logic [NUM_DIV-1:0]           wrap;
    logic [NUM_DIV-1:0][PH_W-1:0] nxt;
  } phaseStrobe_t;
endpackage

// File: rtl/clkgen_phase_ctrl.sv
module clkgen_phase_ctrl
  import clkgen_pkg::*;
#(
  parameter int DIV_CHOP = 2,
  parameter int DIV_AZ   = 16,
  parameter int DIV_CMP  = 80,
  parameter int DIV_GAIN = 200,
  parameter int DIV_FMID = 8,
  parameter int DIV_FSLO = 256
) (
  input  logic         clk,
  input  logic         rst,
  output phaseStrobe_t strb
);
  localparam int DIVS [NUM_DIV] = '{DIV_CHOP, DIV_AZ, DIV_CMP, DIV_GAIN, DIV_FMID, DIV_FSLO};

  logic [NUM_DIV-1:0]           wrapVec;
  logic [NUM_DIV-1:0][PH_W-1:0] nxtVec;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam logic [PH_W-1:0] LAST = PH_W'(DIVS[g] - 1);
    logic [PH_W-1:0] phase;

    assign wrapVec[g] = (phase == LAST);
    assign nxtVec[g]  = (rst || wrapVec[g]) ? '0 : phase + 1'b1;

    always_ff @(posedge clk) begin
      phase <= nxtVec[g];
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
      phase <= LAST); // R10
  end

  assign strb.wrap = wrapVec;
  assign strb.nxt  = nxtVec;
endmodule

// File: rtl/clkgen_wave_dp.sv
module clkgen_wave_dp
  import clkgen_pkg::*;
#(
  parameter int DIV_CHOP = 2,
  parameter int DIV_AZ   = 16,
  parameter int DIV_CMP  = 80,
  parameter int DIV_GAIN = 200,
  parameter int DIV_FMID = 8,
  parameter int DIV_FSLO = 256,
  parameter int GAP      = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  phaseStrobe_t       strb,
  output logic [NUM_OUT-1:0] waveBus
);
  localparam int CHOP_W   = 2 * CHOP_PAIRS;
  localparam int AZ_BASE  = CHOP_W;
  localparam int CMP_BASE = AZ_BASE + 8;
  localparam int GAIN_BIT = CMP_BASE + 6;
  localparam int LO_W     = GAIN_BIT + 1;

  localparam logic [PH_W-1:0] CHOP_HALF = PH_W'(DIV_CHOP / 2);
  localparam logic [PH_W-1:0] AZ_HALF   = PH_W'(DIV_AZ / 2);
  localparam logic [PH_W-1:0] AZ_Z_LO   = PH_W'(GAP);
  localparam logic [PH_W-1:0] AZ_A_LO   = PH_W'(DIV_AZ / 2 + GAP);
  localparam logic [PH_W-1:0] CMP_HALF  = PH_W'(DIV_CMP / 2);
  localparam logic [PH_W-1:0] CMP_1_LO  = PH_W'(GAP);
  localparam logic [PH_W-1:0] CMP_2_LO  = PH_W'(DIV_CMP / 2 + GAP);
  localparam logic [PH_W-1:0] GAIN_HALF = PH_W'(DIV_GAIN / 2);
  localparam logic [PH_W-1:0] FMID_HALF = PH_W'(DIV_FMID / 2);
  localparam logic [PH_W-1:0] FSLO_HALF = PH_W'(DIV_FSLO / 2);

  logic [PH_W-1:0] pChop, pAz, pCmp, pGain, pFmid, pFslo;
  assign pChop = strb.nxt[IDX_CHOP];
  assign pAz   = strb.nxt[IDX_AZ];
  assign pCmp  = strb.nxt[IDX_CMP];
  assign pGain = strb.nxt[IDX_GAIN];
  assign pFmid = strb.nxt[IDX_FMID];
  assign pFslo = strb.nxt[IDX_FSLO];

  // main-path chopper: complementary pairs, no gap at divide by 2
  logic chopA;
  logic [CHOP_W-1:0] chopNext;
  assign chopA = (pChop < CHOP_HALF);
  for (genvar i = 0; i < CHOP_PAIRS; i++) begin : g_chop
    assign chopNext[2*i]   = chopA;
    assign chopNext[2*i+1] = ~chopA;
  end

  // auto-zero ping-pong phases
  logic zeroA, ampA;
  assign zeroA = (pAz >= AZ_Z_LO) && (pAz < AZ_HALF);
  assign ampA  = (pAz >= AZ_A_LO);

  // compensation chopper phases
  logic cmp1, cmp2, cmpSq;
  assign cmp1  = (pCmp >= CMP_1_LO) && (pCmp < CMP_HALF);
  assign cmp2  = (pCmp >= CMP_2_LO);
  assign cmpSq = (pCmp < CMP_HALF);

  logic [LO_W-1:0] loNext;
  logic [2:0]      hiNext;
  always_comb begin
    loNext = '0;
    loNext[CHOP_W-1:0]  = chopNext;
    loNext[AZ_BASE+0]   = zeroA;
    loNext[AZ_BASE+1]   = ampA;
    loNext[AZ_BASE+2]   = ampA;
    loNext[AZ_BASE+3]   = zeroA;
    loNext[AZ_BASE+4]   = ~zeroA;
    loNext[AZ_BASE+5]   = ~ampA;
    loNext[AZ_BASE+6]   = ~ampA;
    loNext[AZ_BASE+7]   = ~zeroA;
    loNext[CMP_BASE+0]  = cmp1;
    loNext[CMP_BASE+1]  = cmp2;
    loNext[CMP_BASE+2]  = cmpSq;
    loNext[CMP_BASE+3]  = ~cmp1;
    loNext[CMP_BASE+4]  = ~cmp2;
    loNext[CMP_BASE+5]  = ~cmpSq;
    loNext[GAIN_BIT]    = (pGain < GAIN_HALF);
    hiNext[0]           = (pFmid < FMID_HALF);
    hiNext[1]           = (pAz < AZ_HALF);
    hiNext[2]           = (pFslo < FSLO_HALF);
  end

  logic [LO_W-1:0] loReg;
  logic [2:0]      hiReg;
  always_ff @(posedge clk) begin
    loReg <= loNext;
    hiReg <= hiNext;
  end

  assign waveBus = {hiReg, clk, loReg};

  logic z0, z1, a0, a1, q1, q2;
  assign z0 = waveBus[AZ_BASE+0];
  assign z1 = waveBus[AZ_BASE+1];
  assign a0 = waveBus[AZ_BASE+2];
  assign a1 = waveBus[AZ_BASE+3];
  assign q1 = waveBus[CMP_BASE+0];
  assign q2 = waveBus[CMP_BASE+1];

  AST_CHOP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (waveBus[0] != $past(waveBus[0]))); // R2
  AST_PINGPONG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(z0 && z1) && !(a0 && a1)); // R4
  AST_AZ_NOVL: assert property (@(posedge clk) disable iff (rst)
    !(z0 && a0)); // R9
  AST_AZ_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(z0) |-> !a0); // R9
  AST_AZ_WRAP_GAP: assert property (@(posedge clk) disable iff (rst)
    strb.wrap[IDX_AZ] |=> (!z0 && !a0)); // R9
  AST_CMP_NOVL: assert property (@(posedge clk) disable iff (rst)
    !(q1 && q2)); // R6
  AST_CMP_SQ: assert property (@(posedge clk) disable iff (rst)
    q1 |-> waveBus[CMP_BASE+2]); // R6
endmodule

// File: rtl/clkgen_multirate.sv
module clkgen_multirate
  import clkgen_pkg::*;
#(
  parameter int DIV_CHOP = 2,
  parameter int DIV_AZ   = 16,
  parameter int DIV_CMP  = 80,
  parameter int DIV_GAIN = 200,
  parameter int DIV_FMID = 8,
  parameter int DIV_FSLO = 256,
  parameter int GAP      = 1
) (
  input  logic               masterClk,
  input  logic               syncRst,
  output logic [NUM_OUT-1:0] phaseBus
);
  phaseStrobe_t strb;

  clkgen_phase_ctrl #(
    .DIV_CHOP(DIV_CHOP), .DIV_AZ(DIV_AZ), .DIV_CMP(DIV_CMP),
    .DIV_GAIN(DIV_GAIN), .DIV_FMID(DIV_FMID), .DIV_FSLO(DIV_FSLO)
  ) ctrl_i (
    .clk  (masterClk),
    .rst  (syncRst),
    .strb (strb)
  );

  clkgen_wave_dp #(
    .DIV_CHOP(DIV_CHOP), .DIV_AZ(DIV_AZ), .DIV_CMP(DIV_CMP),
    .DIV_GAIN(DIV_GAIN), .DIV_FMID(DIV_FMID), .DIV_FSLO(DIV_FSLO),
    .GAP(GAP)
  ) dp_i (
    .clk     (masterClk),
    .rst     (syncRst),
    .strb    (strb),
    .waveBus (phaseBus)
  );
endmodule

// File: tb/clkgen_multirate_tb.sv
`timescale 1ns/100ps
module clkgen_multirate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [24:0] phaseBus;
  int          nChecks = 0;
  int          nFails  = 0;
  int          cyc     = 0;
  bit          done    = 1'b0;

  always #2.5 clk = ~clk;

  clkgen_multirate dut_i (
    .masterClk (clk),
    .syncRst   (rst),
    .phaseBus  (phaseBus)
  );

  // expected word at phase n, bit 21 forced low (checked on its own)
  function automatic logic [24:0] model(int n);
    logic [24:0] w;
    int p2   = n % 2;
    int p16  = n % 16;
    int p80  = n % 80;
    int p200 = n % 200;
    int p8   = n % 8;
    int p256 = n % 256;
    w = '0;
    for (int i = 0; i < 3; i++) begin
      w[2*i]   = (p2 == 0);
      w[2*i+1] = (p2 == 1);
    end
    w[6]  = (p16 >= 1 && p16 <= 7);
    w[8]  = (p16 >= 9);
    w[7]  = w[8];
    w[9]  = w[6];
    w[10] = !w[6]; w[11] = !w[7]; w[12] = !w[8]; w[13] = !w[9];
    w[14] = (p80 >= 1 && p80 <= 39);
    w[15] = (p80 >= 41);
    w[16] = (p80 < 40);
    w[17] = !w[14]; w[18] = !w[15]; w[19] = !w[16];
    w[20] = (p200 < 100);
    w[22] = (p8 < 4);
    w[23] = (p16 < 8);
    w[24] = (p256 < 128);
    return w;
  endfunction

  task automatic check(string req, logic [24:0] act, logic [24:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(int holdCycles);
    @(negedge clk);
    rst = 1'b1;
    repeat (holdCycles) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [24:0] lowWord(logic [24:0] v);
    logic [24:0] r = v;
    r[21] = 1'b0;
    return r;
  endfunction

  // {phase, bit, value, requirement}
  localparam int NVEC = 20;
  localparam logic [39:0] VEC [NVEC] = '{
    {16'd1,   8'd0,  8'd0, 8'd2},   // R2 odd phase low
    {16'd2,   8'd1,  8'd0, 8'd2},   // R2 complement low at even
    {16'd0,   8'd6,  8'd0, 8'd9},   // R9 gap at p=0
    {16'd1,   8'd6,  8'd1, 8'd3},   // R3 zeroing starts
    {16'd7,   8'd6,  8'd1, 8'd3},   // R3 zeroing last cycle
    {16'd8,   8'd8,  8'd0, 8'd9},   // R9 gap at p=8
    {16'd9,   8'd8,  8'd1, 8'd3},   // R3 amplify starts
    {16'd9,   8'd7,  8'd1, 8'd4},   // R4 amp1 zeroes while amp0 amplifies
    {16'd3,   8'd9,  8'd1, 8'd4},   // R4 amp1 amplifies while amp0 zeroes
    {16'd3,   8'd10, 8'd0, 8'd5},   // R5 inverted copy
    {16'd40,  8'd15, 8'd0, 8'd9},   // R9 compensation gap
    {16'd41,  8'd15, 8'd1, 8'd6},   // R6 second phase starts
    {16'd39,  8'd16, 8'd1, 8'd6},   // R6 square last high
    {16'd40,  8'd19, 8'd1, 8'd6},   // R6 inverted square
    {16'd99,  8'd20, 8'd1, 8'd7},   // R7 gain last high
    {16'd100, 8'd20, 8'd0, 8'd7},   // R7 gain low half
    {16'd3,   8'd22, 8'd1, 8'd8},   // R8 div-8 high
    {16'd4,   8'd22, 8'd0, 8'd8},   // R8 div-8 low
    {16'd127, 8'd24, 8'd1, 8'd8},   // R8 div-256 high
    {16'd128, 8'd24, 8'd0, 8'd8}    // R8 div-256 low
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: phase-zero word during reset
    repeat (2) @(negedge clk);
    check("R1 reset word", lowWord(phaseBus), 25'h1D73C15);
    repeat (3) @(negedge clk);
    check("R1 reset hold", lowWord(phaseBus), 25'h1D73C15);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      int ph  = int'(VEC[v][39:24]);
      int bi  = int'(VEC[v][23:16]);
      logic ev = VEC[v][8];
      int rq  = int'(VEC[v][7:0]);
      doReset(1);
      repeat (ph) @(negedge clk);
      nChecks++;
      if (phaseBus[bi] !== ev) begin
        nFails++;
        $display("FAIL R%0d phase=%0d bit=%0d actual=%b expected=%b", rq, ph, bi, phaseBus[bi], ev);
      end
    end

    // full sweep over one complete common period and beyond
    doReset(1);
    for (int n = 0; n < 6500; n++) begin
      check("sweep R2 R3 R4 R5 R6 R7 R8 R9", lowWord(phaseBus), model(n));
      @(negedge clk);
    end

    // R8: bit 21 tracks the master clock level
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check("R8 master high", {24'd0, phaseBus[21]}, 25'd1);
      @(negedge clk); #1;
      check("R8 master low", {24'd0, phaseBus[21]}, 25'd0);
    end

    // R10: reset in mid-run realigns every divider
    doReset(1);
    repeat (1234) @(negedge clk);
    check("R10 before reset", lowWord(phaseBus), model(1234));
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset mid-run", lowWord(phaseBus), 25'h1D73C15);
    rst = 1'b0;
    repeat (37) @(negedge clk);
    check("R10 phase after release", lowWord(phaseBus), model(37));
    repeat (163) @(negedge clk);
    check("R10 phase 200", lowWord(phaseBus), model(200));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule